// File: doc/BRIEF.md
# Pipelined Parity-Checked SPI Register Slave

This block is a 16-bit-frame SPI target in mode 1. The clock idles low, the target samples MOSI on the falling SCK edge, and it shifts MISO out MSB first while chip select is low. SCK, chip select and MOSI are resynchronised into the system clock domain, and edges are found there. The system clock must run at least four times faster than SCK. Each frame ends on the rising edge of chip select, and only then does the block act on it.

A command frame holds a read/write bit, a 14-bit address and an even parity bit. The block answers one frame late. A read places the addressed register in the response of the following frame. A write needs a second frame that carries the data. The response to the command frame holds the old register value, and the response to the data frame holds the new one. Parity errors, wrong clock counts and unknown addresses each set a status bit and a sticky error flag. That flag is carried in every response frame until the host reads the clear address. The block also gives out a write strobe for its two writable settings and a request pulse each time the angle is read.

Top module: `spi_reg_slave`

## Requirements
- R1: Every response frame has the 14-bit data in bits 15:2, the sticky error flag in bit 1, and bit 0 set so that the 16 bits have even parity.
- R2: MISO is enabled only while chip select is low. MOSI is sampled on falling SCK. MISO presents bit 15 after chip select falls and moves to the next bit on each rising SCK except the first.
- R3: A command frame carries read (bit 15 = 1) or write (0), the address in bits 14:1 and even parity in bit 0. A valid read returns the register, sampled when chip select rises, in the response of the next frame.
- R4: A valid write to 0x3F22 (8-bit power setting, reset 0x00) or 0x3FF8 (6-bit gain, reset 0x20) takes a following data frame, with the data in bits 15:2 and the low bits kept. The next response is the old value, and the response after the data frame is the new value. The data frame gives one wr_stb pulse with wr_addr and the full 14-bit wr_data.
- R5: A 16-clock frame with odd parity sets status bit 0 and the error flag, and it does not execute.
- R6: A frame with other than 16 falling SCK edges sets status bit 1 and the error flag, and it does not execute. Its parity is not judged.
- R7: A read of an address not in {0x3F22, 0x3FF8, 0x3FFF, 0x335A, 0x3380, 0x0000}, or a write to an address not in {0x3F22, 0x3FF8, 0x0000}, sets status bit 2 and the error flag.
- R8: The error flag and the status bits stay set until a read of 0x3380. That read clears them, and its response is 0x0000. A read of 0x335A returns the status bits in data bits 2:0.
- R9: Address 0x0000 reads as zero. A write to it takes a data frame, changes nothing and gives no wr_stb.
- R10: A read of 0x3FFF returns the weak-field alarm in bit 13, the strong-field alarm in bit 12 and the angle in bits 9:0, and it gives one angle_req pulse.
- R11: After reset the outputs are idle, and the first response frame is 0x0000.
- R12: A frame in error responds with data 0 and error flag 1. If it was the data frame of a pending write, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for MISO |
| angle_weak | input | 1 | Weak-field alarm to report |
| angle_strong | input | 1 | Strong-field alarm to report |
| angle_in | input | 10 | Angle value to report |
| wr_stb | output | 1 | One-cycle pulse on a register write |
| wr_addr | output | 14 | Address of the write |
| wr_data | output | 14 | Data of the write |
| angle_req | output | 1 | One-cycle pulse on an angle read |

## Verification
The bench aims at the one-frame pipeline. A design that answered in the same frame, or lost the old value of a write, would shift every response by one and fail all later comparisons. It sends frames with bad parity, and with 15 and 17 clocks, including one that arrives as the data of a pending write. A design that still executed those frames would raise an unexpected write strobe or change the gain. It also reads the clear address and the status register. A flag that is not sticky, or a clear that leaves status bits behind, would show up as the wrong bit 1 or the wrong data in the next response.

// File: rtl/spi_reg_slave.sv
`timescale 1ns/1ps
module spi_reg_slave #(
  parameter int FW = 16,
  parameter int PW = 8,
  parameter int GW = 6,
  parameter int ANW = 10,
  parameter logic [FW-3:0] A_PWR = 14'h3F22,
  parameter logic [FW-3:0] A_GAIN = 14'h3FF8,
  parameter logic [FW-3:0] A_ANGLE = 14'h3FFF,
  parameter logic [FW-3:0] A_ERR = 14'h335A,
  parameter logic [FW-3:0] A_CLR = 14'h3380,
  parameter logic [FW-3:0] A_NOP = 14'h0000,
  parameter logic [GW-1:0] GAIN_RST = 6'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck,
  input  logic            cs_n,
  input  logic            mosi,
  output logic            miso,
  output logic            miso_oe,
  input  logic            angle_weak,
  input  logic            angle_strong,
  input  logic [ANW-1:0]  angle_in,
  output logic            wr_stb,
  output logic [FW-3:0]   wr_addr,
  output logic [FW-3:0]   wr_data,
  output logic            angle_req
);
  localparam int DW = FW - 2;
  localparam int CW = $clog2(FW + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FW);
  localparam logic [CW-1:0] CNT_OVER = CW'(FW + 1);

  logic [2:0] sck_m, cs_m;
  logic [1:0] mosi_m;
  logic [CW-1:0] cnt;
  logic [FW-1:0] rx, tx_sr, tx_word;
  logic ef, e_par, e_clk, e_addr, pend;
  logic [DW-1:0] pend_addr;
  logic [PW-1:0] r_pwr;
  logic [GW-1:0] r_gain;
  logic [DW-1:0] cur_val, new_val;
  logic rd_ok, wr_ok;

  wire sck_rise = sck_m[1] & ~sck_m[2];
  wire sck_fall = ~sck_m[1] & sck_m[2];
  wire cs_fall = ~cs_m[1] & cs_m[2];
  wire cs_rise = cs_m[1] & ~cs_m[2];
  wire [DW-1:0] cmd_addr = rx[FW-2:1];
  wire [DW-1:0] data_in = rx[FW-1:2];
  wire clk_bad = cnt != CNT_FULL;
  wire par_bad = ^rx;

  assign miso = tx_sr[FW-1];
  assign miso_oe = ~cs_m[1];

  function automatic logic [FW-1:0] mk(input logic [DW-1:0] d, input logic e);
    return {d, e, ^{d, e}};
  endfunction

  always_comb begin
    cur_val = '0;
    rd_ok = 1'b1;
    case (cmd_addr)
      A_PWR:   cur_val = DW'(r_pwr);
      A_GAIN:  cur_val = DW'(r_gain);
      A_ANGLE: begin
        cur_val[DW-1] = angle_weak;
        cur_val[DW-2] = angle_strong;
        cur_val[ANW-1:0] = angle_in;
      end
      A_ERR:   cur_val[2:0] = {e_addr, e_clk, e_par};
      A_CLR, A_NOP: cur_val = '0;
      default: rd_ok = 1'b0;
    endcase
    wr_ok = (cmd_addr == A_PWR) || (cmd_addr == A_GAIN) || (cmd_addr == A_NOP);
    if (pend_addr == A_PWR) new_val = DW'(data_in[PW-1:0]);
    else if (pend_addr == A_GAIN) new_val = DW'(data_in[GW-1:0]);
    else new_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= '0;
      cs_m <= '1;
      mosi_m <= '0;
    end else begin
      sck_m <= {sck_m[1:0], sck};
      cs_m <= {cs_m[1:0], cs_n};
      mosi_m <= {mosi_m[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rx <= '0;
      tx_sr <= '0;
      tx_word <= '0;
      ef <= 1'b0;
      e_par <= 1'b0;
      e_clk <= 1'b0;
      e_addr <= 1'b0;
      pend <= 1'b0;
      pend_addr <= '0;
      r_pwr <= '0;
      r_gain <= GAIN_RST;
      wr_stb <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      angle_req <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      angle_req <= 1'b0;
      if (cs_fall) begin
        tx_sr <= tx_word;
        cnt <= '0;
      end else if (miso_oe) begin
        if (sck_fall) begin
          rx <= {rx[FW-2:0], mosi_m[1]};
          if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        end
        if (sck_rise && cnt != '0) tx_sr <= {tx_sr[FW-2:0], 1'b0};
      end
      if (cs_rise) begin
        if (clk_bad || par_bad) begin
          if (clk_bad) e_clk <= 1'b1;
          else e_par <= 1'b1;
          ef <= 1'b1;
          pend <= 1'b0;
          tx_word <= mk('0, 1'b1);
        end else if (pend) begin
          pend <= 1'b0;
          if (pend_addr == A_PWR) r_pwr <= data_in[PW-1:0];
          if (pend_addr == A_GAIN) r_gain <= data_in[GW-1:0];
          if (pend_addr == A_PWR || pend_addr == A_GAIN) begin
            wr_stb <= 1'b1;
            wr_addr <= pend_addr;
            wr_data <= data_in;
          end
          tx_word <= mk(new_val, ef);
        end else if ((rx[FW-1] && !rd_ok) || (!rx[FW-1] && !wr_ok)) begin
          e_addr <= 1'b1;
          ef <= 1'b1;
          tx_word <= mk('0, 1'b1);
        end else if (rx[FW-1] && cmd_addr == A_CLR) begin
          ef <= 1'b0;
          e_par <= 1'b0;
          e_clk <= 1'b0;
          e_addr <= 1'b0;
          tx_word <= '0;
        end else begin
          if (!rx[FW-1]) begin
            pend <= 1'b1;
            pend_addr <= cmd_addr;
          end
          angle_req <= rx[FW-1] && cmd_addr == A_ANGLE;
          tx_word <= mk(cur_val, ef);
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave_chk.sv
`timescale 1ns/1ps
module spi_reg_slave_chk #(
  parameter int FW = 16,
  parameter logic [FW-3:0] A_PWR = 14'h3F22,
  parameter logic [FW-3:0] A_GAIN = 14'h3FF8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          miso_oe,
  input logic          wr_stb,
  input logic [FW-3:0] wr_addr,
  input logic          angle_req
);
  p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);
  p_oe_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$past(cs_n, 2) && !$past(cs_n, 3) && $past(rst_n, 3)) |-> miso_oe);
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_wr_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr == A_PWR || wr_addr == A_GAIN));
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && angle_req));
  p_exec_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || angle_req) |-> cs_n);
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.FW(FW), .A_PWR(A_PWR), .A_GAIN(A_GAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .angle_req(angle_req));

// File: tb/spi_reg_slave_bench.sv
`timescale 1ns/1ps
module spi_reg_slave_bench;
  localparam logic [13:0] PWR = 14'h3F22, GAIN = 14'h3FF8, ANG = 14'h3FFF;
  localparam logic [13:0] ERRS = 14'h335A, CLR = 14'h3380, NOP = 14'h0000;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic alo = 0, ahi = 0;
  logic [9:0] ang = 0;
  logic miso, miso_oe, wr_stb, angle_req;
  logic [13:0] wr_addr, wr_data;
  int checks = 0, errors = 0;
  int obs_wr = 0, obs_ang = 0, exp_wr = 0, exp_ang = 0;
  logic [13:0] obs_waddr = 0, obs_wdata = 0, exp_waddr = 0, exp_wdata = 0;
  logic [7:0] m_pwr = 0;
  logic [5:0] m_gain = 6'h20;
  logic m_ef = 0, m_ep = 0, m_ec = 0, m_ea = 0, m_pend = 0, done = 0;
  logic [13:0] m_paddr = 0;
  logic [15:0] exp_tx = 0;

  always #2 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .angle_weak(alo), .angle_strong(ahi),
    .angle_in(ang), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .angle_req(angle_req));

  always @(negedge clk) begin
    if (wr_stb) begin obs_wr++; obs_waddr = wr_addr; obs_wdata = wr_data; end
    if (angle_req) obs_ang++;
  end

  function automatic logic [15:0] mk(input logic [13:0] d, input logic e);
    return {d, e, ^{d, e}};
  endfunction
  function automatic logic [15:0] cmd(input logic rd, input logic [13:0] a);
    return {rd, a, ^{rd, a}};
  endfunction
  function automatic logic [15:0] dat(input logic [13:0] d);
    return {d, 1'b0, ^d};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] got, output logic oe);
    got = 0;
    cs_n = 0;
    #32;
    oe = miso_oe;
    for (int i = 0; i < n; i++) begin
      #16 mosi = (i < 16) ? w[15-i] : 1'b0;
      #16 sck = 1;
      #32 got = {got[14:0], miso};
      sck = 0;
    end
    #32 cs_n = 1;
    #80;
  endtask

  task automatic model(input logic [15:0] w, input int n);
    logic [13:0] d, a, val;
    logic err;
    d = w[15:2]; a = w[14:1]; val = 0; err = 0;
    if (n != 16) begin m_ec = 1; err = 1; end
    else if (^w) begin m_ep = 1; err = 1; end
    if (err) begin
      m_pend = 0;
    end else if (m_pend) begin
      m_pend = 0;
      if (m_paddr == PWR) begin m_pwr = d[7:0]; val = 14'(m_pwr); end
      if (m_paddr == GAIN) begin m_gain = d[5:0]; val = 14'(m_gain); end
      if (m_paddr != NOP) begin exp_wr++; exp_waddr = m_paddr; exp_wdata = d; end
    end else if (w[15]) begin
      case (a)
        PWR: val = 14'(m_pwr);
        GAIN: val = 14'(m_gain);
        ANG: begin val = {alo, ahi, 2'b00, ang}; exp_ang++; end
        ERRS: val = {11'd0, m_ea, m_ec, m_ep};
        CLR: begin m_ef = 0; m_ep = 0; m_ec = 0; m_ea = 0; end
        NOP: val = 0;
        default: begin m_ea = 1; err = 1; end
      endcase
    end else begin
      if (a == PWR || a == GAIN || a == NOP) begin
        val = (a == PWR) ? 14'(m_pwr) : (a == GAIN) ? 14'(m_gain) : 14'd0;
        m_pend = 1;
        m_paddr = a;
      end else begin
        m_ea = 1; err = 1;
      end
    end
    if (err) m_ef = 1;
    exp_tx = err ? mk(0, 1'b1) : mk(val, m_ef);
  endtask

  task automatic frame(input logic [15:0] w, input int n, input string tag);
    logic [15:0] got;
    logic oe;
    xfer(w, n, got, oe);
    check(oe, 1, "R2 enable while selected");
    if (n == 16) begin
      check(got, exp_tx, tag);
      check(^got, 0, "R1 response parity");
    end
    model(w, n);
    check(obs_wr, exp_wr, "R4 strobe count");
    check(obs_ang, exp_ang, "R10 request count");
    if (exp_wr > 0) begin
      check(obs_waddr, exp_waddr, "R4 write address");
      check(obs_wdata, exp_wdata, "R4 write data");
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd7);
    #20 rst_n = 1;
    #20;
    check(miso_oe, 0, "R11 idle enable");
    check(wr_stb, 0, "R11 idle strobe");
    check(angle_req, 0, "R11 idle request");
    frame(cmd(1, GAIN), 16, "R11 first response zero");
    frame(cmd(1, PWR), 16, "R11 gain reset 0x20");
    frame(cmd(1, NOP), 16, "R11 power reset 0");
    frame(cmd(0, PWR), 16, "R9 nop reads zero");
    frame(dat(14'h3FA5), 16, "R4 old value");
    frame(cmd(1, NOP), 16, "R4 new value");
    check(obs_wdata, 14'h3FA5, "R4 full data on strobe");
    ang = 10'h2B7; alo = 1; ahi = 0;
    frame(cmd(1, ANG), 16, "R9 nop zero");
    ang = 10'h000; alo = 0; ahi = 1;
    frame(cmd(1, NOP), 16, "R10 angle sampled at execution");
    frame(cmd(1, GAIN) ^ 16'h0001, 16, "R3 read response");
    frame(cmd(1, ERRS), 16, "R5 error response");
    frame(cmd(1, NOP), 16, "R5 parity status bit");
    frame(cmd(1, CLR), 16, "R8 flag sticky");
    frame(cmd(1, NOP), 16, "R8 clear returns 0x0000");
    frame(cmd(1, PWR), 15, "R6 short frame");
    frame(cmd(1, ERRS), 16, "R6 error response");
    frame(cmd(1, CLR), 17, "R6 clock status bit");
    frame(cmd(1, ERRS), 16, "R12 error response zero");
    frame(cmd(1, 14'h1234), 16, "R6 status");
    frame(cmd(0, ANG), 16, "R7 bad read address");
    frame(cmd(1, ERRS), 16, "R7 bad write address");
    frame(cmd(1, CLR), 16, "R7 address status bit");
    frame(cmd(0, GAIN), 16, "R8 clear response");
    frame(dat(14'h0011) ^ 16'h0001, 16, "R4 old gain");
    check(obs_wr, exp_wr, "R12 dropped write");
    frame(cmd(1, GAIN), 16, "R12 error response");
    frame(cmd(1, CLR), 16, "R12 gain unchanged");
    frame(cmd(0, NOP), 16, "R8 clear");
    frame(dat(14'h1FFF), 16, "R9 nop write old");
    frame(cmd(1, NOP), 16, "R9 nop write new");
    for (int k = 0; k < 240; k++) begin
      logic [15:0] w;
      int n, r;
      ang = 10'($urandom); alo = 1'($urandom); ahi = 1'($urandom);
      r = $urandom_range(0, 99);
      n = 16;
      if (m_pend) w = dat(14'($urandom));
      else begin
        case ($urandom_range(0, 7))
          0: w = cmd(1, PWR);
          1: w = cmd(1, GAIN);
          2: w = cmd(1, ANG);
          3: w = cmd(1, ERRS);
          4: w = cmd(1, CLR);
          5: w = cmd(0, PWR);
          6: w = cmd(0, GAIN);
          default: w = cmd(1'($urandom), 14'($urandom));
        endcase
      end
      if (r < 6) w = w ^ 16'h0001;
      else if (r < 9) n = (r == 7) ? 15 : 17;
      frame(w, n, "R3 random response");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule